// File: doc/BRIEF.md
# Performance Event Counter Unit

This block counts hardware events for performance analysis. Three fixed-function counters each track one dedicated event stream: retired instructions, core cycles while not halted, and reference cycles while not halted. Four programmable counters each pick one of several per-cycle event count inputs, chosen by an event-select word. Every input carries a small count per cycle, because some events can occur more than once in a single cycle.

Software reaches all state through an indexed register port. A write takes effect at the next clock edge, and a read is combinational from the index. A counter advances only when two things are true: the global gate for that counter is on, and its local controls allow counting at the current privilege level. A programmable counter can also apply a threshold, an inverted threshold, or edge detection to its event count. All counters are 48 bits wide and wrap to zero. Each counter has a sticky overflow flag.

Top module: `perf_counter_unit`

## Requirements
- R1: After reset every register reads zero: all counters, event-select words, the fixed control word, the global gate word and the overflow status word.
- R2: Register indices are as follows. Indices 0-2 hold fixed counters 0-2. Indices 3-6 hold programmable counters 0-3. Indices 7-10 hold event-select words 0-3, and only bits 31:0 are kept. Index 11 holds the fixed control word, and only bits 4n and 4n+1 are kept for n=0..2. Index 12 holds the global gate, and only bits 34:32 and 3:0 are kept. Index 13 holds overflow status. Bits that are not kept read as zero, and counters read back 48 bits.
- R3: A write to a counter index loads the written value. When a write and a count fall in the same cycle, the write wins.
- R4: Programmable counter n counts only when its event-select enable bit 22 is set and global gate bit n is set. Counting begins at the first edge after the edge that stores the enabling write.
- R5: Fixed counter n counts only when global gate bit 32+n is set. It adds the per-cycle count of fixed event input n. Fixed control bit 4n allows counting in kernel mode, and bit 4n+1 allows counting in user mode.
- R6: A programmable counter counts in user mode (priv_user=1) only if event-select bit 16 is set. It counts in kernel mode (priv_user=0) only if bit 17 is set.
- R7: Event-select bits 7:0 pick event input k, which is prog_ev[4k+3:4k]. A value of 8 or more selects nothing. When bits 31:24 are zero and bit 18 is clear, the counter adds the selected input's count each cycle.
- R8: When the threshold field (bits 31:24) is nonzero, the counter adds 1 in each cycle where the count is at least the threshold. When invert bit 23 is set, it adds 1 when the count is below the threshold instead.
- R9: When edge bit 18 is set, the counter adds 1 only on a 0-to-1 change of the threshold condition. With a zero threshold, that condition is "count is nonzero".
- R10: A counter passing 2^48-1 wraps modulo 2^48 and sets its sticky overflow flag. Flags use the same bit positions as the global gate word. Writing 1 to a flag bit clears it, and writing 0 has no effect. A new overflow in the same cycle as a clear leaves the flag set.
- R11: A counter that is not enabled holds its value whatever the event inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index for both read and write |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for reg_addr (combinational) |
| priv_user | input | 1 | 1 = user mode, 0 = kernel mode |
| fix_ev | input | 12 | Per-cycle counts of the fixed events, 4 bits each |
| prog_ev | input | 32 | Per-cycle counts of the selectable events, 4 bits each |

## Verification
All state can be read back, so a corrupted counter, gate or flag shows up at the next read of its index. A wrong enable or qualifier shows up as a count that is off by a multiple of the event count after a known number of cycles. A stale edge-detect history shows up as one extra or one missing count on the first cycle of a pattern. An overflow error shows up as a flag that is wrong on the cycle right after the wrap, or that stays wrong after a clear write.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
    localparam int CNT_W       = 48;
    localparam int EV_W        = 4;
    localparam int N_EVT       = 8;
    localparam int N_FIX       = 3;
    localparam int N_PROG      = 4;
    localparam int N_CTR       = N_FIX + N_PROG;
    localparam int DATA_W      = 64;
    localparam int ADDR_W      = 4;
    localparam int FCTL_W      = 4 * N_FIX;
    localparam int GLB_FIX_LSB = 32;

    // counter n sits at index n; event-select words follow
    localparam int A_SEL0 = N_CTR;
    localparam int A_FCTL = A_SEL0 + N_PROG;
    localparam int A_GCTL = A_FCTL + 1;
    localparam int A_OVF  = A_GCTL + 1;

    typedef struct packed {
        logic [7:0] cmask;
        logic       inv;
        logic       en;
        logic       any;
        logic       intr;
        logic       pin;
        logic       edg;
        logic       os;
        logic       usr;
        logic [7:0] umask;
        logic [7:0] evsel;
    } evtsel_t;

    function automatic logic [FCTL_W-1:0] fctl_mask();
        logic [FCTL_W-1:0] m;
        m = '0;
        for (int i = 0; i < N_FIX; i++) begin
            m[4*i]   = 1'b1;
            m[4*i+1] = 1'b1;
        end
        return m;
    endfunction

    // word layout -> counter-index vector (fixed first, then programmable)
    function automatic logic [N_CTR-1:0] gate_unpack(input logic [DATA_W-1:0] w);
        return {w[N_PROG-1:0], w[GLB_FIX_LSB +: N_FIX]};
    endfunction

    function automatic logic [DATA_W-1:0] gate_pack(input logic [N_CTR-1:0] v);
        logic [DATA_W-1:0] w;
        w = '0;
        w[GLB_FIX_LSB +: N_FIX] = v[N_FIX-1:0];
        w[N_PROG-1:0]           = v[N_CTR-1:N_FIX];
        return w;
    endfunction
endpackage

// File: rtl/pcu_counter.sv
module pcu_counter #(
    parameter int CNT_W = 48,
    parameter int INC_W = 4
) (
    input  logic [CNT_W-1:0] cur,
    input  logic [INC_W-1:0] inc,
    output logic [CNT_W-1:0] nxt,
    output logic             carry
);
    always_comb begin
        {carry, nxt} = {1'b0, cur} + (CNT_W + 1)'(inc);
        p_wrap_low_r10: assert (!carry || (nxt < CNT_W'(inc)));
    end
endmodule

// File: rtl/pcu_prog_qual.sv
module pcu_prog_qual
    import pcu_pkg::*;
#(
    parameter int EV_W  = 4,
    parameter int N_EVT = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  evtsel_t                sel,
    input  logic                   glb_en,
    input  logic                   priv_user,
    input  logic [N_EVT*EV_W-1:0]  ev_bus,
    output logic [EV_W-1:0]        inc
);
    logic [EV_W-1:0] ev_cnt;
    logic [7:0]      ev8;
    logic [7:0]      thr;
    logic            cond;
    logic            hit;
    logic            allowed;
    logic            raw_mode;
    logic            prev_d, prev_q;

    always_comb begin
        ev_cnt = '0;
        for (int e = 0; e < N_EVT; e++) begin
            if (sel.evsel == 8'(e)) ev_cnt = ev_bus[e*EV_W +: EV_W];
        end
        ev8      = 8'(ev_cnt);
        thr      = (sel.cmask == 8'd0) ? 8'd1 : sel.cmask;
        cond     = sel.inv ? (ev8 < thr) : (ev8 >= thr);
        hit      = sel.edg ? (cond && !prev_q) : cond;
        raw_mode = (sel.cmask == 8'd0) && !sel.edg;
        allowed  = glb_en && sel.en &&
                   ((priv_user && sel.usr) || (!priv_user && sel.os));
        if (!allowed)      inc = '0;
        else if (raw_mode) inc = ev_cnt;
        else               inc = EV_W'(hit);
        prev_d = cond;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    p_thresh_unit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel.cmask != 8'd0) |-> (inc <= EV_W'(1)));

    p_edge_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel.edg && inc != '0) ##1 ($stable(ev_bus) && $stable(sel)) |-> (inc == '0));
endmodule

// File: rtl/perf_counter_unit.sv
module perf_counter_unit
    import pcu_pkg::*;
#(
    parameter int CW = pcu_pkg::CNT_W,
    parameter int EW = pcu_pkg::EV_W,
    parameter int NE = pcu_pkg::N_EVT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr_en,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic                priv_user,
    input  logic [N_FIX*EW-1:0] fix_ev,
    input  logic [NE*EW-1:0]    prog_ev
);
    localparam logic [FCTL_W-1:0] FMASK = fctl_mask();

    typedef struct packed {
        logic [N_CTR-1:0][CW-1:0] cnt;
        evtsel_t [N_PROG-1:0]     sel;
        logic [FCTL_W-1:0]        fctl;
        logic [N_CTR-1:0]         gen;
        logic [N_CTR-1:0]         ovf;
    } state_t;

    state_t st_d, st_q;
    logic [N_CTR-1:0][EW-1:0] inc;
    logic [N_CTR-1:0][CW-1:0] nxt;
    logic [N_CTR-1:0]         carry;

    genvar g;
    generate
        for (g = 0; g < N_FIX; g++) begin : g_fix
            logic allowed;
            assign allowed = st_q.gen[g] &&
                             (priv_user ? st_q.fctl[4*g+1] : st_q.fctl[4*g]);
            assign inc[g]  = allowed ? fix_ev[g*EW +: EW] : '0;
        end
        for (g = 0; g < N_PROG; g++) begin : g_prog
            pcu_prog_qual #(.EV_W(EW), .N_EVT(NE)) u_qual (
                .clk       (clk),
                .rst_n     (rst_n),
                .sel       (st_q.sel[g]),
                .glb_en    (st_q.gen[N_FIX+g]),
                .priv_user (priv_user),
                .ev_bus    (prog_ev),
                .inc       (inc[N_FIX+g])
            );
        end
        for (g = 0; g < N_CTR; g++) begin : g_ctr
            pcu_counter #(.CNT_W(CW), .INC_W(EW)) u_ctr (
                .cur   (st_q.cnt[g]),
                .inc   (inc[g]),
                .nxt   (nxt[g]),
                .carry (carry[g])
            );
        end
    endgenerate

    always_comb begin
        logic [N_CTR-1:0] clr;
        st_d = st_q;
        clr  = (reg_wr_en && reg_addr == ADDR_W'(A_OVF)) ? gate_unpack(reg_wdata) : '0;
        st_d.ovf = st_q.ovf & ~clr;
        for (int k = 0; k < N_CTR; k++) begin
            if (reg_wr_en && reg_addr == ADDR_W'(k)) begin
                st_d.cnt[k] = reg_wdata[CW-1:0];
            end else begin
                st_d.cnt[k] = nxt[k];
                if (carry[k]) st_d.ovf[k] = 1'b1;
            end
        end
        for (int p = 0; p < N_PROG; p++) begin
            if (reg_wr_en && reg_addr == ADDR_W'(A_SEL0 + p))
                st_d.sel[p] = evtsel_t'(reg_wdata[31:0]);
        end
        if (reg_wr_en && reg_addr == ADDR_W'(A_FCTL))
            st_d.fctl = reg_wdata[FCTL_W-1:0] & FMASK;
        if (reg_wr_en && reg_addr == ADDR_W'(A_GCTL))
            st_d.gen = gate_unpack(reg_wdata);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        for (int k = 0; k < N_CTR; k++)
            if (reg_addr == ADDR_W'(k)) reg_rdata = DATA_W'(st_q.cnt[k]);
        for (int p = 0; p < N_PROG; p++)
            if (reg_addr == ADDR_W'(A_SEL0 + p)) reg_rdata = DATA_W'(st_q.sel[p]);
        if (reg_addr == ADDR_W'(A_FCTL)) reg_rdata = DATA_W'(st_q.fctl);
        if (reg_addr == ADDR_W'(A_GCTL)) reg_rdata = gate_pack(st_q.gen);
        if (reg_addr == ADDR_W'(A_OVF))  reg_rdata = gate_pack(st_q.ovf);
    end

    p_write_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == ADDR_W'(N_FIX)) |=>
            (st_q.cnt[N_FIX] == $past(reg_wdata[CW-1:0])));

    p_hold_disabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.gen[N_FIX] && !(reg_wr_en && reg_addr == ADDR_W'(N_FIX))) |=>
            $stable(st_q.cnt[N_FIX]));

    p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovf[0] && !(reg_wr_en && reg_addr == ADDR_W'(A_OVF))) |=> st_q.ovf[0]);

    p_no_count_without_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.gen[1] && !(reg_wr_en && reg_addr == ADDR_W'(1))) |=> $stable(st_q.cnt[1]));
endmodule

// File: tb/perf_counter_unit_tb.sv
module perf_counter_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 13;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

    // {addr, write data, expected readback}
    localparam logic [131:0] VEC [NVEC] = '{
        {4'd7,  ONES,                    64'h0000_0000_FFFF_FFFF},
        {4'd8,  64'h1234_5678_9ABC_DEF0, 64'h0000_0000_9ABC_DEF0},
        {4'd11, ONES,                    64'h0000_0000_0000_0333},
        {4'd12, ONES,                    64'h0000_0007_0000_000F},
        {4'd0,  ONES,                    64'h0000_FFFF_FFFF_FFFF},
        {4'd4,  64'hABCD_0000_1111_2222, 64'h0000_0000_1111_2222},
        {4'd13, ONES,                    64'h0},
        {4'd12, 64'h0,                   64'h0},
        {4'd11, 64'h0,                   64'h0},
        {4'd7,  64'h0,                   64'h0},
        {4'd8,  64'h0,                   64'h0},
        {4'd0,  64'h0,                   64'h0},
        {4'd4,  64'h0,                   64'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        priv_user = 1'b1;
    logic [11:0] fix_ev = '0;
    logic [31:0] prog_ev = '0;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic [63:0] ref0;

    always #(CLK_PERIOD/2) clk = ~clk;

    perf_counter_unit u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .priv_user(priv_user),
        .fix_ev(fix_ev), .prog_ev(prog_ev)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [63:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [63:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [63:0] exp);
        logic [63:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic pev(input int slot, input logic [3:0] v);
        prog_ev[slot*4 +: 4] = v;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1: reset state of every register
        for (int a = 0; a < 14; a++) rd_chk("R1 reset", 4'(a), 64'h0);

        // R2: table of writes and readbacks (events idle)
        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][131:128], VEC[i][127:64]);
            rd_chk("R2 map", VEC[i][131:128], VEC[i][63:0]);
        end

        // R4/R7: raw counting, gated by global bit and delayed one edge
        priv_user = 1'b1;
        pev(2, 4'd3);
        wr(4'd7, 64'h0041_0002);
        step(2);
        rd_chk("R4 no global gate", 4'd3, 64'd0);
        wr(4'd12, 64'h1);
        step(5);
        pev(2, 4'd0);
        rd_chk("R4 R7 raw count", 4'd3, 64'd15);

        // R6: privilege qualification
        priv_user = 1'b0;
        pev(2, 4'd3);
        step(4);
        rd_chk("R6 user-only in kernel", 4'd3, 64'd15);
        wr(4'd7, 64'h0042_0002);
        step(2);
        pev(2, 4'd0);
        rd_chk("R6 os in kernel", 4'd3, 64'd21);

        // R8: threshold, then inverted threshold
        wr(4'd8, 64'h0242_0001);
        wr(4'd12, 64'h3);
        pev(1, 4'd1); step(1);
        pev(1, 4'd2); step(1);
        pev(1, 4'd3); step(1);
        pev(1, 4'd0); step(1);
        pev(1, 4'd5); step(1);
        pev(1, 4'd0);
        rd_chk("R8 threshold", 4'd4, 64'd3);
        wr(4'd8, 64'h02C2_0001);
        wr(4'd4, 64'h0);
        pev(1, 4'd1); step(1);
        pev(1, 4'd2); step(1);
        pev(1, 4'd0); step(1);
        pev(1, 4'd3); step(1);
        pev(1, 4'd2);
        rd_chk("R8 invert", 4'd4, 64'd2);
        wr(4'd8, 64'h0);
        pev(1, 4'd0);

        // R9: edge detect with threshold 2, then with zero threshold
        wr(4'd9, 64'h0246_0003);
        wr(4'd12, 64'h7);
        pev(3, 4'd3); step(1);
        pev(3, 4'd3); step(1);
        pev(3, 4'd0); step(1);
        pev(3, 4'd3); step(1);
        pev(3, 4'd0); step(1);
        pev(3, 4'd0); step(1);
        pev(3, 4'd3); step(1);
        pev(3, 4'd0);
        rd_chk("R9 edge threshold", 4'd5, 64'd3);
        step(1);
        wr(4'd9, 64'h0046_0003);
        wr(4'd5, 64'h0);
        pev(3, 4'd1); step(1);
        pev(3, 4'd5); step(1);
        pev(3, 4'd0); step(1);
        pev(3, 4'd2); step(1);
        pev(3, 4'd2); step(1);
        pev(3, 4'd0);
        rd_chk("R9 edge nonzero", 4'd5, 64'd2);

        // R7: out-of-range select counts nothing; last valid index counts
        wr(4'd10, 64'h0042_0009);
        wr(4'd12, 64'hF);
        prog_ev = 32'hFFFF_FFFF;
        step(4);
        prog_ev = '0;
        rd_chk("R7 select out of range", 4'd6, 64'd0);
        pev(7, 4'd2);
        wr(4'd10, 64'h0042_0007);
        step(3);
        pev(7, 4'd0);
        rd_chk("R7 select last index", 4'd6, 64'd6);

        // R5 and R11: fixed counters by privilege; programmable held when gated off
        wr(4'd12, 64'h0);
        rd(4'd3, ref0);
        fix_ev = {4'd1, 4'd1, 4'd2};
        prog_ev = 32'hFFFF_FFFF;
        wr(4'd11, 64'h312);
        wr(4'd12, 64'h7_0000_0000);
        priv_user = 1'b1;
        step(4);
        priv_user = 1'b0;
        step(3);
        fix_ev = '0;
        prog_ev = '0;
        rd_chk("R5 fixed0 user only", 4'd0, 64'd8);
        rd_chk("R5 fixed1 kernel only", 4'd1, 64'd3);
        rd_chk("R5 fixed2 both", 4'd2, 64'd7);
        rd_chk("R11 hold when gated", 4'd3, ref0);

        // R3: write wins over count in the same cycle
        fix_ev = {4'd0, 4'd1, 4'd0};
        wr(4'd1, 64'd100);
        rd_chk("R3 write wins", 4'd1, 64'd100);
        step(2);
        fix_ev = '0;
        rd_chk("R3 counts after write", 4'd1, 64'd102);

        // R10: wrap, sticky flag, write-one-to-clear, set beats clear
        wr(4'd2, 64'h0000_FFFF_FFFF_FFFE);
        fix_ev = {4'd3, 4'd0, 4'd0};
        step(1);
        fix_ev = '0;
        rd_chk("R10 wrap value", 4'd2, 64'd1);
        rd_chk("R10 flag set", 4'd13, 64'h4_0000_0000);
        step(1);
        wr(4'd13, 64'h0);
        rd_chk("R10 flag sticky", 4'd13, 64'h4_0000_0000);
        wr(4'd13, 64'h4_0000_0000);
        rd_chk("R10 flag cleared", 4'd13, 64'h0);
        wr(4'd2, 64'h0000_FFFF_FFFF_FFFF);
        fix_ev = {4'd1, 4'd0, 4'd0};
        wr(4'd13, 64'h4_0000_0000);
        fix_ev = '0;
        rd_chk("R10 set beats clear", 4'd13, 64'h4_0000_0000);
        rd_chk("R10 wrap to zero", 4'd2, 64'd0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule